// File: doc/BRIEF.md
# Pipelined Signed Complex Multiplier

This block multiplies two complex numbers whose real and imaginary parts are two's-complement integers. Operand A has parts of width WA and operand B has parts of width WB. The block forms the real result as the product of the two real parts minus the product of the two imaginary parts. It forms the imaginary result as the sum of the two cross products.

The exact result needs WA+WB+1 bits. Each product needs WA+WB bits, and adding or subtracting two such products adds one more. When the output width WO is set below that natural width, the low bits are dropped. A build-time mode chooses how they are dropped: plain truncation, which floors toward minus infinity, or round-half-up.

One operand pair can be accepted every cycle. A qualifying strobe travels alongside the data, and each result appears a fixed three clock edges after its operands are captured.

Top module: `cmul_top`

## Requirements
- R1: When valid, the real output equals a_re*b_re - a_im*b_im. At full width (WO = WA+WB+1) the value is exact, and a zero operand A gives zero.
- R2: When valid, the imaginary output equals a_re*b_im + a_im*b_re. At full width the value is exact, and operands with zero imaginary parts give a zero imaginary result.
- R3: The natural width WA+WB+1 holds every result without wrap. With 8-bit parts, all parts at -128 gives an imaginary result of +32768, and (-128,-128)*(-128,127) gives a real result of +32640.
- R4: In truncate mode (MODE = RND_TRUNC), with D = WA+WB+1-WO, each output is the exact result arithmetically shifted right by D, which floors toward minus infinity. For example, -16 with D = 5 gives -1.
- R5: In round-half-up mode (MODE = RND_HALF_UP), each output is (exact + 2^(D-1)) arithmetically shifted right by D. For example, +16 with D = 5 gives 1, and -16 gives 0.
- R6: out_valid rises exactly three rising edges after the edge at which in_valid is sampled high, for back-to-back and for isolated inputs. out_valid is never high otherwise.
- R7: While out_valid is low, out_re and out_im keep the value of the last valid result.
- R8: While rst is high and after it is released, until the first result, out_valid, out_re and out_im are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on a_*/b_* are valid this cycle |
| a_re | input | WA | Real part of operand A, signed |
| a_im | input | WA | Imaginary part of operand A, signed |
| b_re | input | WB | Real part of operand B, signed |
| b_im | input | WB | Imaginary part of operand B, signed |
| out_valid | output | 1 | Result on out_re/out_im is valid |
| out_re | output | WO | Real part of result, signed |
| out_im | output | WO | Imaginary part of result, signed |

## Verification
Each result is due on the third rising edge after the edge that samples in_valid. That is one edge for the input registers, one for the products and one for the sum, difference and narrowing. The scoreboard stores the cycle number of each accepted operand pair with its expected values. The monitor samples on the falling edge and requires that every result pops an entry issued exactly three cycles earlier. In cycles without a result, it checks that the outputs hold the last result.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    typedef enum logic {
        RND_TRUNC   = 1'b0,
        RND_HALF_UP = 1'b1
    } rnd_mode_e;

    localparam int unsigned CMUL_LATENCY = 3;

    function automatic int natural_width(input int wa, input int wb);
        return wa + wb + 1;
    endfunction

    function automatic int dropped_bits(input int nw, input int wo);
        return nw - wo;
    endfunction

endpackage

// File: rtl/cmul_in_reg.sv
module cmul_in_reg #(
    parameter int WA = 8,
    parameter int WB = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [WA-1:0] a_re,
    input  logic signed [WA-1:0] a_im,
    input  logic signed [WB-1:0] b_re,
    input  logic signed [WB-1:0] b_im,
    output logic                 s1_valid,
    output logic signed [WA-1:0] s1_ar,
    output logic signed [WA-1:0] s1_ai,
    output logic signed [WB-1:0] s1_br,
    output logic signed [WB-1:0] s1_bi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_ar    <= '0;
            s1_ai    <= '0;
            s1_br    <= '0;
            s1_bi    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_ar <= a_re;
                s1_ai <= a_im;
                s1_br <= b_re;
                s1_bi <= b_im;
            end
        end
    end
endmodule

// File: rtl/cmul_prod.sv
module cmul_prod #(
    parameter int WA = 8,
    parameter int WB = 8,
    localparam int PW = WA + WB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s1_valid,
    input  logic signed [WA-1:0] s1_ar,
    input  logic signed [WA-1:0] s1_ai,
    input  logic signed [WB-1:0] s1_br,
    input  logic signed [WB-1:0] s1_bi,
    output logic                 s2_valid,
    output logic signed [PW-1:0] p_rr,
    output logic signed [PW-1:0] p_ii,
    output logic signed [PW-1:0] p_ri,
    output logic signed [PW-1:0] p_ir
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_valid <= 1'b0;
            p_rr     <= '0;
            p_ii     <= '0;
            p_ri     <= '0;
            p_ir     <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                p_rr <= PW'(s1_ar) * PW'(s1_br);
                p_ii <= PW'(s1_ai) * PW'(s1_bi);
                p_ri <= PW'(s1_ar) * PW'(s1_bi);
                p_ir <= PW'(s1_ai) * PW'(s1_br);
            end
        end
    end
endmodule

// File: rtl/cmul_narrow.sv
module cmul_narrow
    import cmul_pkg::*;
#(
    parameter int        NW   = 17,
    parameter int        WO   = 12,
    parameter rnd_mode_e MODE = RND_HALF_UP,
    localparam int       D    = dropped_bits(NW, WO)
) (
    input  logic signed [NW-1:0] full_val,
    output logic signed [WO-1:0] narrow_val
);
    if (D == 0) begin : g_pass
        assign narrow_val = full_val[WO-1:0];
    end else if (MODE == RND_TRUNC) begin : g_trunc
        assign narrow_val = full_val[NW-1:D];
    end else begin : g_round
        localparam logic signed [NW:0] HALF = (NW+1)'(1) << (D - 1);
        logic signed [NW:0] biased;
        assign biased     = (NW+1)'(full_val) + HALF;
        assign narrow_val = biased[NW-1:D];
    end
endmodule

// File: rtl/cmul_top.sv
module cmul_top
    import cmul_pkg::*;
#(
    parameter int        WA   = 8,
    parameter int        WB   = 8,
    parameter int        WO   = 12,
    parameter rnd_mode_e MODE = RND_HALF_UP,
    localparam int       PW   = WA + WB,
    localparam int       NW   = natural_width(WA, WB)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [WA-1:0] a_re,
    input  logic signed [WA-1:0] a_im,
    input  logic signed [WB-1:0] b_re,
    input  logic signed [WB-1:0] b_im,
    output logic                 out_valid,
    output logic signed [WO-1:0] out_re,
    output logic signed [WO-1:0] out_im
);
    if (WO > NW) begin : g_wo_too_wide
        $error("cmul_top: WO must not exceed WA+WB+1");
    end
    if (WO < 2) begin : g_wo_too_narrow
        $error("cmul_top: WO must be at least 2");
    end

    logic                 s1_valid;
    logic signed [WA-1:0] s1_ar, s1_ai;
    logic signed [WB-1:0] s1_br, s1_bi;
    logic                 s2_valid;
    logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
    logic signed [NW-1:0] re_full, im_full;
    logic signed [WO-1:0] re_nar, im_nar;

    cmul_in_reg #(.WA(WA), .WB(WB)) u_in (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .s1_valid(s1_valid), .s1_ar(s1_ar), .s1_ai(s1_ai),
        .s1_br(s1_br), .s1_bi(s1_bi)
    );

    cmul_prod #(.WA(WA), .WB(WB)) u_prod (
        .clk(clk), .rst(rst), .s1_valid(s1_valid),
        .s1_ar(s1_ar), .s1_ai(s1_ai), .s1_br(s1_br), .s1_bi(s1_bi),
        .s2_valid(s2_valid), .p_rr(p_rr), .p_ii(p_ii),
        .p_ri(p_ri), .p_ir(p_ir)
    );

    assign re_full = NW'(p_rr) - NW'(p_ii);
    assign im_full = NW'(p_ri) + NW'(p_ir);

    cmul_narrow #(.NW(NW), .WO(WO), .MODE(MODE)) u_nar_re (
        .full_val(re_full), .narrow_val(re_nar)
    );
    cmul_narrow #(.NW(NW), .WO(WO), .MODE(MODE)) u_nar_im (
        .full_val(im_full), .narrow_val(im_nar)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= s2_valid;
            if (s2_valid) begin
                out_re <= re_nar;
                out_im <= im_nar;
            end
        end
    end
endmodule

// File: rtl/cmul_checker.sv
module cmul_checker #(
    parameter int WA = 8,
    parameter int WB = 8,
    parameter int WO = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic signed [WA-1:0] a_re,
    input logic signed [WA-1:0] a_im,
    input logic signed [WB-1:0] b_re,
    input logic signed [WB-1:0] b_im,
    input logic                 out_valid,
    input logic signed [WO-1:0] out_re,
    input logic signed [WO-1:0] out_im
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_re) && $stable(out_im)));

    assert_zero_operand_R1: assert property (@(posedge clk) disable iff (rst)
        ((since_rst == 2'd3) && $past(in_valid && a_re == '0 && a_im == '0, 3))
        |-> (out_re == '0 && out_im == '0));

    assert_real_only_R2: assert property (@(posedge clk) disable iff (rst)
        ((since_rst == 2'd3) && $past(in_valid && a_im == '0 && b_im == '0, 3))
        |-> (out_im == '0));

    assert_no_valid_in_reset_R8: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

bind cmul_top cmul_checker #(.WA(WA), .WB(WB), .WO(WO)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/cmul_top_tb_top.sv
`timescale 1ns/1ps
module cmul_top_tb_top;
    import cmul_pkg::*;

    localparam int WA  = 8;
    localparam int WB  = 8;
    localparam int NW  = WA + WB + 1;
    localparam int WON = 12;
    localparam int D   = NW - WON;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [WA-1:0] a_re = '0, a_im = '0;
    logic signed [WB-1:0] b_re = '0, b_im = '0;

    logic                  v_r, v_t, v_f;
    logic signed [WON-1:0] re_r, im_r, re_t, im_t;
    logic signed [NW-1:0]  re_f, im_f;

    always #2.5 clk = ~clk;

    cmul_top #(.WA(WA), .WB(WB), .WO(WON), .MODE(RND_HALF_UP)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_valid(v_r), .out_re(re_r), .out_im(im_r));
    cmul_top #(.WA(WA), .WB(WB), .WO(WON), .MODE(RND_TRUNC)) dut_t (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_valid(v_t), .out_re(re_t), .out_im(im_t));
    cmul_top #(.WA(WA), .WB(WB), .WO(NW), .MODE(RND_HALF_UP)) dut_f (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
        .out_valid(v_f), .out_re(re_f), .out_im(im_f));

    typedef struct {
        longint re;
        longint im;
        longint cyc;
    } exp_t;

    exp_t   sb_q[$];
    longint cyc = 0;
    int     n_checks = 0;
    int     n_errors = 0;
    bit     have_last = 1'b0;
    longint last_re_r, last_im_r, last_re_t, last_im_t, last_re_f, last_im_f;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint trunc_of(input longint v);
        return v >>> D;
    endfunction

    function automatic longint round_of(input longint v);
        return (v + (longint'(1) <<< (D - 1))) >>> D;
    endfunction

    task automatic send(input int ar, input int ai, input int br, input int bi);
        exp_t e;
        @(negedge clk);
        a_re = WA'(ar); a_im = WA'(ai); b_re = WB'(br); b_im = WB'(bi);
        in_valid = 1'b1;
        e.re  = longint'(ar) * br - longint'(ai) * bi;
        e.im  = longint'(ar) * bi + longint'(ai) * br;
        e.cyc = cyc;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a_re = WA'($urandom); a_im = WA'($urandom);
            b_re = WB'($urandom); b_im = WB'($urandom);
        end
    endtask

    // Monitor: results are due three cycles after issue (R6)
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                check("R6 valid agreement trunc", longint'(v_t), longint'(v_r));
                check("R6 valid agreement full", longint'(v_f), longint'(v_r));
                if (v_r) begin
                    if (sb_q.size() == 0) begin
                        check("R6 unexpected out_valid", 1, 0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        check("R6 latency", cyc - e.cyc, 3);
                        check("R1 real full width", longint'(re_f), e.re);
                        check("R2 imag full width", longint'(im_f), e.im);
                        check("R4 real truncated", longint'(re_t), trunc_of(e.re));
                        check("R4 imag truncated", longint'(im_t), trunc_of(e.im));
                        check("R5 real rounded", longint'(re_r), round_of(e.re));
                        check("R5 imag rounded", longint'(im_r), round_of(e.im));
                    end
                    have_last = 1'b1;
                    last_re_r = longint'(re_r); last_im_r = longint'(im_r);
                    last_re_t = longint'(re_t); last_im_t = longint'(im_t);
                    last_re_f = longint'(re_f); last_im_f = longint'(im_f);
                end else if (have_last) begin
                    check("R7 hold real rounded", longint'(re_r), last_re_r);
                    check("R7 hold imag rounded", longint'(im_r), last_im_r);
                    check("R7 hold real trunc", longint'(re_t), last_re_t);
                    check("R7 hold imag trunc", longint'(im_t), last_im_t);
                    check("R7 hold real full", longint'(re_f), last_re_f);
                    check("R7 hold imag full", longint'(im_f), last_im_f);
                end else begin
                    check("R8 out_valid low before first result", longint'(v_r), 0);
                    check("R8 out_re zero before first result", longint'(re_r), 0);
                    check("R8 out_im zero before first result", longint'(im_r), 0);
                end
            end
        end
    end

    initial begin
        fork
            begin
                rst = 1'b1;
                repeat (4) @(negedge clk);
                check("R8 reset out_valid", longint'(v_r), 0);
                check("R8 reset out_re", longint'(re_r), 0);
                check("R8 reset out_im", longint'(im_f), 0);
                @(negedge clk);
                rst = 1'b0;
                idle(3);
                // R3 extremes of the natural width
                send(-128, -128, -128, -128);
                send(-128, -128, -128, 127);
                send(127, 127, 127, 127);
                send(127, -128, -128, 127);
                idle(4);
                // R4/R5 exact half and neighbours at D = 5
                send(1, 0, 16, 0);
                send(-1, 0, 16, 0);
                send(1, 0, 15, 0);
                send(-1, 0, 17, 0);
                send(0, 1, 0, -16);
                send(0, 0, 0, 0);
                idle(2);
                // R1/R2 zero-operand and real-only patterns
                send(0, 0, 55, -77);
                send(13, 0, -9, 0);
                idle(5);
                // R6 back-to-back random stream with gaps
                for (int n = 0; n < 300; n++) begin
                    send($signed(WA'($urandom)), $signed(WA'($urandom)),
                         $signed(WB'($urandom)), $signed(WB'($urandom)));
                    if (n % 7 == 3) idle(n % 4 + 1);
                end
                idle(8);
                check("R6 all results delivered", sb_q.size(), 0);
            end
            begin
                repeat (100000) @(posedge clk);
                n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule